// File: doc/BRIEF.md
# I2C Acknowledge Slot Controller

This block decides what happens on SDA during the ninth (acknowledge) clock that follows each byte on an I2C bus. It serves both roles. As the receiver of a byte it pulls SDA low to acknowledge, or leaves the line released. As the sender of a byte it keeps SDA released and reads back the bit that the far end drives. Shifting bytes and detecting start or stop conditions happen elsewhere. A neighbouring clock generator gives this block single-cycle strobes:
- byte complete: the 8th SCL pulse has fallen, and the low phase before the 9th rising edge has begun;
- mid-high: the middle of the 9th high phase;
- SCL fell: the 9th clock has dropped;
- start seen: a start condition has been detected.

Software-style controls choose whether an acknowledge slot exists at all (`ack_slot_en_i`) and which value a receiver returns (`nack_sel_i`: 0 means acknowledge, 1 means not-acknowledge). During reception of an address byte, with acknowledge return selected, the comparison of the received 7-bit address with the device's own address decides the reply on its own. A match acknowledges and a mismatch leaves SDA high. The result of that comparison is held as a flag until the next start.

The controller is a four-state machine:
- `ST_IDLE`: no slot is open.
- `ST_RX_SLOT`: receiver slot. The drive enable carries the decided reply.
- `ST_TX_WAIT`: transmitter slot, waiting for the mid-high strobe.
- `ST_TX_HELD`: transmitter slot, the bit has already been sampled.

Transitions:
- Start seen: any state goes to `ST_IDLE`. This has the highest priority.
- Byte complete: any state goes to `ST_IDLE` when the slot is disabled, to `ST_TX_WAIT` when transmitting, and to `ST_RX_SLOT` when receiving.
- Mid-high: `ST_TX_WAIT` goes to `ST_TX_HELD`.
- SCL fell: `ST_RX_SLOT`, `ST_TX_WAIT` and `ST_TX_HELD` each go back to `ST_IDLE`.

Top module: `i2c_ack_ctrl`

## Requirements
- R1: With `ack_slot_en_i` = 0, a byte-complete strobe opens no slot, and `sda_pull_o` is 0 in the following cycle.
- R2: With `ack_slot_en_i` = 1, every byte-complete strobe opens a slot. From the next cycle the block drives or samples according to its role.
- R3: As receiver (`is_tx_i` = 0) of a data byte (`addr_phase_i` = 0) with `nack_sel_i` = 0, `sda_pull_o` is 1 from the cycle after the byte-complete strobe until the slot closes.
- R4: As receiver of a data byte with `nack_sel_i` = 1, `sda_pull_o` stays 0 through the slot.
- R5: As receiver of an address byte (`addr_phase_i` = 1) with `nack_sel_i` = 0, `sda_pull_o` is 1 in the slot exactly when `rx_addr_i` equals `own_addr_i`.
- R6: As receiver of an address byte with `nack_sel_i` = 1, `sda_pull_o` stays 0 even when the addresses match.
- R7: As transmitter (`is_tx_i` = 1), `sda_pull_o` stays 0 through the slot.
- R8: In a transmitter slot, the first mid-high strobe samples `sda_i`. The cycle after it, `ack_rcvd_o` = NOT `sda_i` (1 = ACK, low seen) and `ack_valid_o` pulses for one cycle. `ack_rcvd_o` holds until the next sample. Mid-high strobes outside a waiting transmitter slot are ignored.
- R9: At each byte-complete strobe with `addr_phase_i` = 1 and `is_tx_i` = 0, `addr_match_o` takes (`rx_addr_i` == `own_addr_i`) in the next cycle, whether or not a slot is enabled. It holds otherwise. A start strobe clears it.
- R10: The cycle after an SCL-fell strobe or a start strobe, `sda_pull_o` is 0 and the slot is closed. While neither strobe nor a new byte-complete strobe arrives, `sda_pull_o` holds.
- R11: During reset, `sda_pull_o`, `addr_match_o`, `ack_rcvd_o` and `ack_valid_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ack_slot_en_i | input | 1 | 1 = an acknowledge slot follows each byte |
| nack_sel_i | input | 1 | Receiver reply: 0 = ACK (pull low), 1 = NACK (release) |
| is_tx_i | input | 1 | 1 = this device sent the byte |
| addr_phase_i | input | 1 | 1 = the byte just completed is an address byte |
| rx_addr_i | input | ADDR_W | Received address |
| own_addr_i | input | ADDR_W | Own device address |
| start_i | input | 1 | Start-condition strobe |
| byte_done_i | input | 1 | Byte-complete strobe (low phase before 9th rise) |
| mid_high_i | input | 1 | Mid-high strobe of the SCL pulse |
| scl_fell_i | input | 1 | SCL falling-edge strobe |
| sda_i | input | 1 | Sampled SDA line level |
| sda_pull_o | output | 1 | Open-drain enable: 1 = pull SDA low |
| ack_rcvd_o | output | 1 | Transmitter result: 1 = ACK, 0 = NACK |
| ack_valid_o | output | 1 | One-cycle pulse when `ack_rcvd_o` is refreshed |
| addr_match_o | output | 1 | Address comparison result of the last address byte |

## Verification
Every output is registered, so each result is due one clock edge after its strobe:
- the drive enable follows a byte-complete, SCL-fell or start strobe;
- the match flag follows a byte-complete or start strobe;
- the sampled bit and its valid pulse follow a mid-high strobe.

The bench drives inputs on falling edges. A behavioural model is updated on the same rising edge as the design, and on the next falling edge the model and the design's outputs are compared. Every result is therefore checked in exactly the cycle it is due, with no slack.

// File: rtl/i2c_ack_pkg.sv
package i2c_ack_pkg;

    // Slot controller states
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_RX_SLOT = 2'd1,
        ST_TX_WAIT = 2'd2,
        ST_TX_HELD = 2'd3
    } ack_state_t;

    // Strobes from the clock generator, bundled
    typedef struct packed {
        logic start;
        logic byte_done;
        logic mid_high;
        logic scl_fell;
    } ack_evt_t;

endpackage

// File: rtl/i2c_ack_addr_cmp.sv
module i2c_ack_addr_cmp #(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              capture_i,
    input  logic [ADDR_W-1:0] rx_addr_i,
    input  logic [ADDR_W-1:0] own_addr_i,
    output logic              hit_o,
    output logic              match_o
);

    logic [ADDR_W-1:0] bit_eq;

    // Per-bit equality, reduced below
    for (genvar b = 0; b < ADDR_W; b++) begin : g_eq
        assign bit_eq[b] = ~(rx_addr_i[b] ^ own_addr_i[b]);
    end

    assign hit_o = &bit_eq;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_o <= 1'b0;
        end else if (clear_i) begin
            match_o <= 1'b0;
        end else if (capture_i) begin
            match_o <= hit_o;
        end
    end

endmodule

// File: rtl/i2c_ack_fsm.sv
module i2c_ack_fsm
    import i2c_ack_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  ack_evt_t   evt_i,
    input  logic       slot_en_i,
    input  logic       is_tx_i,
    output ack_state_t state_o,
    output ack_state_t next_o
);

    ack_state_t state_q, state_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state decode: start, then byte complete, then per-state strobes
    always_comb begin
        state_d = state_q;
        if (evt_i.start) begin
            state_d = ST_IDLE;
        end else if (evt_i.byte_done) begin
            if (!slot_en_i) begin
                state_d = ST_IDLE;
            end else if (is_tx_i) begin
                state_d = ST_TX_WAIT;
            end else begin
                state_d = ST_RX_SLOT;
            end
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    state_d = ST_IDLE;
                end
                ST_RX_SLOT: begin
                    if (evt_i.scl_fell) state_d = ST_IDLE;
                end
                ST_TX_WAIT: begin
                    if (evt_i.scl_fell)      state_d = ST_IDLE;
                    else if (evt_i.mid_high) state_d = ST_TX_HELD;
                end
                ST_TX_HELD: begin
                    if (evt_i.scl_fell) state_d = ST_IDLE;
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    assign state_o = state_q;
    assign next_o  = state_d;

endmodule

// File: rtl/i2c_ack_out.sv
module i2c_ack_out
    import i2c_ack_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  ack_state_t state_i,
    input  ack_state_t next_i,
    input  logic       byte_done_i,
    input  logic       nack_sel_i,
    input  logic       addr_phase_i,
    input  logic       hit_i,
    input  logic       sda_i,
    output logic       sda_pull_o,
    output logic       ack_rcvd_o,
    output logic       ack_valid_o
);

    logic reply_low;
    logic sample_now;

    // Receiver reply: on an address byte the comparison wins, but only
    // while acknowledge return is selected.
    always_comb begin
        if (nack_sel_i) begin
            reply_low = 1'b0;
        end else if (addr_phase_i) begin
            reply_low = hit_i;
        end else begin
            reply_low = 1'b1;
        end
    end

    assign sample_now = (state_i == ST_TX_WAIT) && (next_i == ST_TX_HELD);

    // Output register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sda_pull_o  <= 1'b0;
            ack_rcvd_o  <= 1'b0;
            ack_valid_o <= 1'b0;
        end else begin
            ack_valid_o <= sample_now;
            if (sample_now) begin
                ack_rcvd_o <= ~sda_i;
            end
            if (next_i != ST_RX_SLOT) begin
                sda_pull_o <= 1'b0;
            end else if (byte_done_i) begin
                sda_pull_o <= reply_low;
            end
        end
    end

endmodule

// File: rtl/i2c_ack_ctrl.sv
module i2c_ack_ctrl
    import i2c_ack_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ack_slot_en_i,
    input  logic              nack_sel_i,
    input  logic              is_tx_i,
    input  logic              addr_phase_i,
    input  logic [ADDR_W-1:0] rx_addr_i,
    input  logic [ADDR_W-1:0] own_addr_i,
    input  logic              start_i,
    input  logic              byte_done_i,
    input  logic              mid_high_i,
    input  logic              scl_fell_i,
    input  logic              sda_i,
    output logic              sda_pull_o,
    output logic              ack_rcvd_o,
    output logic              ack_valid_o,
    output logic              addr_match_o
);

    ack_evt_t   evt;
    ack_state_t state_q, state_d;
    logic       hit;
    logic       capture;

    assign evt.start     = start_i;
    assign evt.byte_done = byte_done_i;
    assign evt.mid_high  = mid_high_i;
    assign evt.scl_fell  = scl_fell_i;

    assign capture = byte_done_i && addr_phase_i && !is_tx_i;

    i2c_ack_addr_cmp #(.ADDR_W(ADDR_W)) u_cmp (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (start_i),
        .capture_i  (capture),
        .rx_addr_i  (rx_addr_i),
        .own_addr_i (own_addr_i),
        .hit_o      (hit),
        .match_o    (addr_match_o)
    );

    i2c_ack_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_i     (evt),
        .slot_en_i (ack_slot_en_i),
        .is_tx_i   (is_tx_i),
        .state_o   (state_q),
        .next_o    (state_d)
    );

    i2c_ack_out u_out (
        .clk          (clk),
        .rst_n        (rst_n),
        .state_i      (state_q),
        .next_i       (state_d),
        .byte_done_i  (byte_done_i),
        .nack_sel_i   (nack_sel_i),
        .addr_phase_i (addr_phase_i),
        .hit_i        (hit),
        .sda_i        (sda_i),
        .sda_pull_o   (sda_pull_o),
        .ack_rcvd_o   (ack_rcvd_o),
        .ack_valid_o  (ack_valid_o)
    );

endmodule

// File: rtl/i2c_ack_ctrl_chk.sv
module i2c_ack_ctrl_chk #(
    parameter int ADDR_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ack_slot_en_i,
    input logic              nack_sel_i,
    input logic              is_tx_i,
    input logic              addr_phase_i,
    input logic [ADDR_W-1:0] rx_addr_i,
    input logic [ADDR_W-1:0] own_addr_i,
    input logic              start_i,
    input logic              byte_done_i,
    input logic              mid_high_i,
    input logic              scl_fell_i,
    input logic              sda_i,
    input logic              sda_pull_o,
    input logic              ack_rcvd_o,
    input logic              ack_valid_o,
    input logic              addr_match_o
);

    logic new_byte;
    assign new_byte = byte_done_i && !start_i;

    assert_no_slot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        new_byte && !ack_slot_en_i |=> !sda_pull_o);

    assert_data_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
        new_byte && ack_slot_en_i && !is_tx_i && !addr_phase_i && !nack_sel_i
        |=> sda_pull_o);

    assert_data_nack_R4: assert property (@(posedge clk) disable iff (!rst_n)
        new_byte && ack_slot_en_i && !is_tx_i && !addr_phase_i && nack_sel_i
        |=> !sda_pull_o);

    assert_addr_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        new_byte && ack_slot_en_i && !is_tx_i && addr_phase_i && !nack_sel_i
        |=> sda_pull_o == $past(rx_addr_i == own_addr_i));

    assert_addr_nack_R6: assert property (@(posedge clk) disable iff (!rst_n)
        new_byte && ack_slot_en_i && !is_tx_i && addr_phase_i && nack_sel_i
        |=> !sda_pull_o);

    assert_tx_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        new_byte && ack_slot_en_i && is_tx_i |=> !sda_pull_o);

    assert_sample_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid_o |-> ack_rcvd_o == !$past(sda_i));

    assert_valid_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid_o |=> !ack_valid_o);

    assert_match_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> !addr_match_o);

    assert_match_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        new_byte && addr_phase_i && !is_tx_i
        |=> addr_match_o == $past(rx_addr_i == own_addr_i));

    assert_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i || (scl_fell_i && !byte_done_i)) |=> !sda_pull_o);

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i && !byte_done_i && !scl_fell_i |=> $stable(sda_pull_o));

endmodule

bind i2c_ack_ctrl i2c_ack_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_i2c_ack_ctrl.sv
module sim_i2c_ack_ctrl;

    localparam int AW = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0, nack = 1'b0, tx = 1'b0, addr = 1'b0;
    logic [AW-1:0] rxa = '0, own = 7'h2A;
    logic st = 1'b0, bd = 1'b0, mh = 1'b0, fl = 1'b0;
    logic far_low = 1'b0;
    logic sda_line;
    logic pull, rcvd, vld, match;

    int checks = 0;
    int fails  = 0;
    bit armed  = 1'b0;

    // Behavioural reference state
    int    m_slot = 0;          // 0 none, 1 rx, 2 tx waiting, 3 tx sampled
    bit    m_pull = 0, m_rcvd = 0, m_vld = 0, m_match = 0;
    string m_tag = "R11";

    always #2.5 clk = ~clk;

    assign sda_line = !(pull || far_low);

    i2c_ack_ctrl #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .ack_slot_en_i(en), .nack_sel_i(nack),
        .is_tx_i(tx), .addr_phase_i(addr), .rx_addr_i(rxa), .own_addr_i(own),
        .start_i(st), .byte_done_i(bd), .mid_high_i(mh), .scl_fell_i(fl),
        .sda_i(sda_line), .sda_pull_o(pull), .ack_rcvd_o(rcvd),
        .ack_valid_o(vld), .addr_match_o(match)
    );

    always @(posedge clk) begin
        armed <= 1'b1;
        m_vld = 0;
        if (!rst_n) begin
            m_slot = 0; m_pull = 0; m_rcvd = 0; m_match = 0; m_tag = "R11";
        end else if (st) begin
            m_slot = 0; m_pull = 0; m_match = 0; m_tag = "R10";
        end else if (bd) begin
            if (addr && !tx) m_match = (rxa == own);
            if (!en) begin
                m_slot = 0; m_pull = 0; m_tag = "R1";
            end else if (tx) begin
                m_slot = 2; m_pull = 0; m_tag = "R7";
            end else begin
                m_slot = 1;
                if (addr) begin
                    m_pull = !nack && (rxa == own);
                    m_tag = nack ? "R6" : "R5";
                end else begin
                    m_pull = !nack;
                    m_tag = nack ? "R4" : "R2/R3";
                end
            end
        end else if (fl && m_slot != 0) begin
            m_slot = 0; m_pull = 0; m_tag = "R10";
        end else if (mh && m_slot == 2) begin
            m_rcvd = !sda_line; m_vld = 1; m_slot = 3;
        end
    end

    task automatic cmp(input bit act, input bit exp, input string tag, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0b expected %0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (armed) begin
            cmp(pull,  m_pull,  rst_n ? m_tag : "R11", "sda_pull");
            cmp(match, m_match, rst_n ? "R9"  : "R11", "addr_match");
            cmp(rcvd,  m_rcvd,  rst_n ? "R8"  : "R11", "ack_rcvd");
            cmp(vld,   m_vld,   rst_n ? "R8"  : "R11", "ack_valid");
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic strobe(input bit s, input bit b, input bit m, input bit f);
        @(negedge clk);
        st = s; bd = b; mh = m; fl = f;
        @(negedge clk);
        st = 0; bd = 0; mh = 0; fl = 0;
    endtask

    // One full ninth-clock: byte complete, mid-high, fall
    task automatic slot(input bit e, input bit t, input bit a, input bit n, input logic [AW-1:0] r);
        @(negedge clk);
        en = e; tx = t; addr = a; nack = n; rxa = r;
        strobe(0, 1, 0, 0);
        idle(2);
        strobe(0, 0, 1, 0);
        idle(2);
        strobe(0, 0, 0, 1);
        idle(2);
    endtask

    initial begin
        idle(4);
        @(negedge clk) rst_n = 1'b1;
        idle(2);
        // R2, R3 / R4: receiver data bytes
        slot(1, 0, 0, 0, 7'h00);
        slot(1, 0, 0, 1, 7'h00);
        // R1: slot disabled
        slot(0, 0, 0, 0, 7'h00);
        // R5 / R6 / R9: address bytes, match then mismatch
        slot(1, 0, 1, 0, 7'h2A);
        slot(1, 0, 1, 0, 7'h2B);
        slot(1, 0, 1, 1, 7'h2A);
        slot(0, 0, 1, 0, 7'h2A);   // R9: match captured without a slot
        strobe(1, 0, 0, 0);        // R9: start clears
        idle(2);
        // R7 / R8: transmitter, far end acknowledges then not
        far_low = 1'b1;
        slot(1, 1, 0, 0, 7'h00);
        far_low = 1'b0;
        slot(1, 1, 0, 0, 7'h00);
        // R8: stray mid-high outside a slot is ignored
        far_low = 1'b1;
        strobe(0, 0, 1, 0);
        idle(2);
        far_low = 1'b0;
        // R8: fall before mid-high means no sample
        @(negedge clk) begin en = 1; tx = 1; end
        strobe(0, 1, 0, 0);
        strobe(0, 0, 0, 1);
        strobe(0, 0, 1, 0);
        idle(2);
        // R10: start in the middle of a receiver slot
        @(negedge clk) begin tx = 0; addr = 0; nack = 0; end
        strobe(0, 1, 0, 0);
        idle(2);
        strobe(1, 0, 0, 0);
        idle(2);
        // R2: back-to-back bytes without a fall, role swap
        strobe(0, 1, 0, 0);
        @(negedge clk) tx = 1;
        strobe(0, 1, 0, 0);
        strobe(0, 0, 0, 1);
        // Sweep of address patterns
        for (int i = 0; i < 16; i++) begin
            slot(1, 0, 1, i[0], (i[1] ? own : own ^ 7'(i)));
        end
        // R11: reset mid-slot
        @(negedge clk) begin tx = 0; addr = 0; nack = 0; end
        strobe(0, 1, 0, 0);
        @(negedge clk) rst_n = 1'b0;
        idle(3);
        @(negedge clk) rst_n = 1'b1;
        idle(3);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule